// File: doc/BRIEF.md
# Link Fault Handler

This block belongs to the reconciliation layer between a MAC and a 10-gigabit media-independent interface. Each clock carries one column: four byte lanes on a 32-bit data word, plus one control bit per lane. The block watches the receive column stream for fault sequences. A fault sequence is one of two fixed columns. One reports a fault detected on the near side, called a local fault. The other reports a fault seen by the far end, called a remote fault. From these the block decides what the transmit path carries.

When local faults are present, the block replaces the MAC's transmit columns with a steady stream of remote-fault sequences. This tells the far end that our receiver is broken. When remote faults are present, the block sends idle columns instead of MAC data. Local fault always takes precedence over remote fault. This layer is the only place where remote-fault sequences are created.

Two status flags report the fault state to management software. A raised local flag tells software to inspect the receive-path devices. A raised remote flag tells software to inspect the transmit-path devices.

Top module: `lfh_link_fault`

## Requirements
- R1: While reset is asserted, and after reset is released, both flags are 0 and the transmit outputs equal the MAC inputs. An asserted reset clears a raised flag at once.
- R2: A fault sequence is a column with control bits 4'b0001, lane 0 (bits 7:0) equal to 0x9C, lanes 1 and 2 equal to 0x00, and lane 3 (bits 31:24) equal to 0x01 for local or 0x02 for remote. A column that differs in any field counts as a fault-free column.
- R3: The fourth local sequence of a run raises local_fault on the next clock. While local_fault is set, tx_data is 0x0200009C and tx_ctrl is 4'b0001, whatever the MAC drives.
- R4: The fourth remote sequence of a run raises remote_fault on the next clock, unless local_fault is set. While remote_fault is set, tx_data is 0x07070707 and tx_ctrl is 4'b1111.
- R5: Three sequences of one type do not raise a flag.
- R6: A sequence continues a run only if fewer than 128 fault-free columns came since the previous sequence. Otherwise it starts a new run with a count of one.
- R7: A sequence whose type differs from the previous sequence starts a new run with a count of one.
- R8: A raised flag clears after 128 consecutive fault-free columns. After 127 such columns it is still set.
- R9: While local_fault is set, remote sequences neither change the flags nor count toward clearing.
- R10: While remote_fault is set, four local sequences switch the state to local fault.
- R11: The two flags are never set together. With both flags at 0, the transmit outputs follow the MAC inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Received column data, lane 0 in bits 7:0 |
| rx_ctrl | input | 4 | Received control bit per lane |
| mac_data | input | 32 | Transmit column data from the MAC |
| mac_ctrl | input | 4 | Transmit control bits from the MAC |
| tx_data | output | 32 | Transmit column data to the interface |
| tx_ctrl | output | 4 | Transmit control bits to the interface |
| local_fault | output | 1 | Local fault state flag |
| remote_fault | output | 1 | Remote fault state flag |

## Verification
Each kind of corrupted internal state shows up at the ports in a predictable way:
- A wrong run count or type memory moves the rising edge of a flag by at least one column away from the fourth sequence. The bench checks the flags immediately after the third and the fourth sequence.
- A wrong quiet counter makes a flag drop one column too early or too late. This is observed after exactly 127 and 128 fault-free columns.
- A wrong state shows in tx_data and tx_ctrl in the same cycle, because the transmit mux is combinational on the registered state.

// File: rtl/lfh_pkg.sv
package lfh_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int COL_W  = LANES * LANE_W;

    localparam logic [LANE_W-1:0] SEQ_CHAR    = 8'h9C;
    localparam logic [LANE_W-1:0] IDLE_CHAR   = 8'h07;
    localparam logic [LANE_W-1:0] CODE_LOCAL  = 8'h01;
    localparam logic [LANE_W-1:0] CODE_REMOTE = 8'h02;

    typedef enum logic [1:0] {FK_NONE, FK_LOCAL, FK_REMOTE} fault_kind_e;
    typedef enum logic [1:0] {LS_OK, LS_LOCAL, LS_REMOTE} link_state_e;
endpackage

// File: rtl/lfh_seq_detect.sv
module lfh_seq_detect
    import lfh_pkg::*;
(
    input  logic [COL_W-1:0] rx_data,
    input  logic [LANES-1:0] rx_ctrl,
    output fault_kind_e      kind
);
    logic              pad_zero;
    logic              frame_ok;
    logic [LANE_W-1:0] code;

    always_comb begin
        pad_zero = 1'b1;
        for (int i = 1; i < LANES - 1; i++) begin
            if (rx_data[i*LANE_W +: LANE_W] != '0) pad_zero = 1'b0;
        end
        code     = rx_data[COL_W-1 -: LANE_W];
        frame_ok = (rx_ctrl == LANES'(1)) && (rx_data[LANE_W-1:0] == SEQ_CHAR) && pad_zero;
        kind     = FK_NONE;
        if (frame_ok && code == CODE_LOCAL)  kind = FK_LOCAL;
        if (frame_ok && code == CODE_REMOTE) kind = FK_REMOTE;
    end
endmodule

// File: rtl/lfh_fault_fsm.sv
module lfh_fault_fsm
    import lfh_pkg::*;
#(
    parameter int SEQ_NEEDED = 4,
    parameter int WINDOW     = 128,
    parameter int QUIET      = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  fault_kind_e kind,
    output link_state_e state
);
    localparam int CNT_W = $clog2(SEQ_NEEDED + 1);
    localparam int SPAN  = (WINDOW > QUIET) ? WINDOW : QUIET;
    localparam int QW    = $clog2(SPAN + 1);

    typedef struct packed {
        link_state_e      state;
        fault_kind_e      last;
        logic [CNT_W-1:0] count;
        logic [QW-1:0]    quiet;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        if (kind != FK_NONE) begin
            d.quiet = '0;
            if (q.state != LS_LOCAL) begin
                if (kind != q.last || q.count == '0 || q.quiet >= QW'(WINDOW))
                    d.count = CNT_W'(1);
                else if (q.count < CNT_W'(SEQ_NEEDED))
                    d.count = q.count + 1'b1;
                d.last = kind;
                if (d.count == CNT_W'(SEQ_NEEDED))
                    d.state = (kind == FK_LOCAL) ? LS_LOCAL : LS_REMOTE;
            end
        end else begin
            if (q.quiet < QW'(QUIET)) d.quiet = q.quiet + 1'b1;
            if (d.quiet == QW'(QUIET)) begin
                d.state = LS_OK;
                d.count = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: LS_OK, last: FK_NONE, count: '0, quiet: '0};
        else        q <= d;
    end

    assign state = q.state;
endmodule

// File: rtl/lfh_tx_mux.sv
module lfh_tx_mux
    import lfh_pkg::*;
(
    input  link_state_e      state,
    input  logic [COL_W-1:0] mac_data,
    input  logic [LANES-1:0] mac_ctrl,
    output logic [COL_W-1:0] tx_data,
    output logic [LANES-1:0] tx_ctrl
);
    logic [COL_W-1:0] rf_data, idle_data;
    logic [LANES-1:0] rf_ctrl, idle_ctrl;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign idle_data[g*LANE_W +: LANE_W] = IDLE_CHAR;
        assign idle_ctrl[g]                  = 1'b1;
        assign rf_data[g*LANE_W +: LANE_W]   = (g == 0)         ? SEQ_CHAR :
                                               (g == LANES - 1) ? CODE_REMOTE : '0;
        assign rf_ctrl[g]                    = (g == 0);
    end

    always_comb begin
        case (state)
            LS_LOCAL:  begin tx_data = rf_data;   tx_ctrl = rf_ctrl;   end
            LS_REMOTE: begin tx_data = idle_data; tx_ctrl = idle_ctrl; end
            default:   begin tx_data = mac_data;  tx_ctrl = mac_ctrl;  end
        endcase
    end
endmodule

// File: rtl/lfh_link_fault.sv
module lfh_link_fault
    import lfh_pkg::*;
#(
    parameter int SEQ_NEEDED = 4,
    parameter int WINDOW     = 128,
    parameter int QUIET      = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] rx_data,
    input  logic [LANES-1:0] rx_ctrl,
    input  logic [COL_W-1:0] mac_data,
    input  logic [LANES-1:0] mac_ctrl,
    output logic [COL_W-1:0] tx_data,
    output logic [LANES-1:0] tx_ctrl,
    output logic             local_fault,
    output logic             remote_fault
);
    fault_kind_e kind;
    link_state_e state;

    lfh_seq_detect u_det (
        .rx_data (rx_data),
        .rx_ctrl (rx_ctrl),
        .kind    (kind)
    );

    lfh_fault_fsm #(
        .SEQ_NEEDED (SEQ_NEEDED),
        .WINDOW     (WINDOW),
        .QUIET      (QUIET)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .state (state)
    );

    lfh_tx_mux u_mux (
        .state    (state),
        .mac_data (mac_data),
        .mac_ctrl (mac_ctrl),
        .tx_data  (tx_data),
        .tx_ctrl  (tx_ctrl)
    );

    assign local_fault  = (state == LS_LOCAL);
    assign remote_fault = (state == LS_REMOTE);
endmodule

// File: rtl/lfh_link_fault_chk.sv
module lfh_link_fault_chk
    import lfh_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [COL_W-1:0] rx_data,
    input logic [LANES-1:0] rx_ctrl,
    input logic [COL_W-1:0] mac_data,
    input logic [LANES-1:0] mac_ctrl,
    input logic [COL_W-1:0] tx_data,
    input logic [LANES-1:0] tx_ctrl,
    input logic             local_fault,
    input logic             remote_fault
);
    logic is_loc, is_rem;
    assign is_loc = (rx_ctrl == 4'b0001) && (rx_data == 32'h0100_009C);
    assign is_rem = (rx_ctrl == 4'b0001) && (rx_data == 32'h0200_009C);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(local_fault && remote_fault)); // R11
    AST_PASS_WHEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!local_fault && !remote_fault) |-> (tx_data == mac_data && tx_ctrl == mac_ctrl)); // R1
    AST_SEND_RF_ON_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        local_fault |-> (tx_data == 32'h0200_009C && tx_ctrl == 4'b0001)); // R3
    AST_SEND_IDLE_ON_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        remote_fault |-> (tx_data == 32'h0707_0707 && tx_ctrl == 4'b1111)); // R4
    AST_LOCAL_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_fault) |-> $past(is_loc)); // R3
    AST_LOCAL_HOLDS_ON_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (local_fault && is_rem) |=> local_fault); // R9
    AST_REMOTE_CLEARS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(remote_fault) && !local_fault) |-> $past(!is_loc && !is_rem)); // R8
endmodule

bind lfh_link_fault lfh_link_fault_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_data      (rx_data),
    .rx_ctrl      (rx_ctrl),
    .mac_data     (mac_data),
    .mac_ctrl     (mac_ctrl),
    .tx_data      (tx_data),
    .tx_ctrl      (tx_ctrl),
    .local_fault  (local_fault),
    .remote_fault (remote_fault)
);

// File: tb/sim_lfh_link_fault.sv
module sim_lfh_link_fault;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_data, mac_data, tx_data;
    logic [3:0]  rx_ctrl, mac_ctrl, tx_ctrl;
    logic        local_fault, remote_fault;
    int          checks = 0;
    int          fails  = 0;

    always #4 clk = ~clk;

    lfh_link_fault u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_data      (rx_data),
        .rx_ctrl      (rx_ctrl),
        .mac_data     (mac_data),
        .mac_ctrl     (mac_ctrl),
        .tx_data      (tx_data),
        .tx_ctrl      (tx_ctrl),
        .local_fault  (local_fault),
        .remote_fault (remote_fault)
    );

    // Kinds: 0 clean data, 1 local seq, 2 remote seq, 3 near miss (lane 3 = 0x03)
    // Fields: {req[15:12], kind[11:10], rep[9:2], exp_local[1], exp_remote[0]}
    localparam int NV = 15;
    localparam logic [15:0] VEC [NV] = '{
        {4'd5,  2'd1, 8'd3,   1'b0, 1'b0},  // R5 three locals
        {4'd3,  2'd1, 8'd1,   1'b1, 1'b0},  // R3 fourth local
        {4'd8,  2'd0, 8'd127, 1'b1, 1'b0},  // R8 127 clean, still set
        {4'd8,  2'd0, 8'd1,   1'b0, 1'b0},  // R8 128th clean clears
        {4'd4,  2'd2, 8'd4,   1'b0, 1'b1},  // R4 four remotes
        {4'd10, 2'd1, 8'd3,   1'b0, 1'b1},  // R10 three locals in remote
        {4'd10, 2'd1, 8'd1,   1'b1, 1'b0},  // R10 fourth local wins
        {4'd9,  2'd2, 8'd10,  1'b1, 1'b0},  // R9 remotes in local
        {4'd8,  2'd0, 8'd128, 1'b0, 1'b0},  // R8 clear
        {4'd2,  2'd3, 8'd6,   1'b0, 1'b0},  // R2 near miss ignored
        {4'd7,  2'd1, 8'd2,   1'b0, 1'b0},  // R7 two locals
        {4'd7,  2'd2, 8'd1,   1'b0, 1'b0},  // R7 type change
        {4'd7,  2'd1, 8'd3,   1'b0, 1'b0},  // R7 run restarted
        {4'd7,  2'd1, 8'd1,   1'b1, 1'b0},  // R7 fourth after restart
        {4'd8,  2'd0, 8'd128, 1'b0, 1'b0}   // R8 clear
    };

    task automatic drive(input int kind, input int idx);
        case (kind)
            1:       begin rx_ctrl = 4'b0001; rx_data = 32'h0100_009C; end
            2:       begin rx_ctrl = 4'b0001; rx_data = 32'h0200_009C; end
            3:       begin rx_ctrl = 4'b0001; rx_data = 32'h0300_009C; end
            default: begin rx_ctrl = 4'b0000; rx_data = 32'hA5C3_0000 + 32'(idx); end
        endcase
    endtask

    task automatic send(input int kind, input int n);
        for (int i = 0; i < n; i++) begin
            drive(kind, i);
            @(negedge clk);
        end
    endtask

    task automatic expect_state(input int req, input bit el, input bit er);
        logic [31:0] ed;
        logic [3:0]  ec;
        #1;
        ed = el ? 32'h0200_009C : (er ? 32'h0707_0707 : mac_data);
        ec = el ? 4'b0001 : (er ? 4'b1111 : mac_ctrl);
        checks++;
        if (local_fault !== el || remote_fault !== er) begin
            fails++;
            $display("FAIL R%0d flags: got local=%b remote=%b expected local=%b remote=%b",
                     req, local_fault, remote_fault, el, er);
        end
        checks++;
        if (tx_data !== ed || tx_ctrl !== ec) begin
            fails++;
            $display("FAIL R%0d tx: got %h/%b expected %h/%b", req, tx_data, tx_ctrl, ed, ec);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        mac_data = 32'h1234_5678;
        mac_ctrl = 4'b0000;
        drive(0, 0);
        repeat (3) @(negedge clk);
        expect_state(1, 1'b0, 1'b0);              // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        expect_state(1, 1'b0, 1'b0);              // R1 after reset

        for (int v = 0; v < NV; v++) begin
            send(int'(VEC[v][11:10]), int'(VEC[v][9:2]));
            expect_state(int'(VEC[v][15:12]), VEC[v][1], VEC[v][0]);
        end

        // R11 pass-through follows MAC in the same cycle
        mac_data = 32'hDEAD_BEEF; mac_ctrl = 4'b1010;
        expect_state(11, 1'b0, 1'b0);

        // R2 wrong control bits with the right bytes
        for (int i = 0; i < 4; i++) begin
            rx_ctrl = 4'b0000; rx_data = 32'h0100_009C;
            @(negedge clk);
        end
        expect_state(2, 1'b0, 1'b0);
        // R2 nonzero middle lane
        for (int i = 0; i < 4; i++) begin
            rx_ctrl = 4'b0001; rx_data = 32'h0101_009C;
            @(negedge clk);
        end
        expect_state(2, 1'b0, 1'b0);
        send(0, 128);

        // R6 gaps of 127 clean columns keep the run going
        for (int k = 0; k < 3; k++) begin
            send(1, 1);
            send(0, 127);
        end
        expect_state(6, 1'b0, 1'b0);
        send(1, 1);
        expect_state(6, 1'b1, 1'b0);
        // R3 MAC data is replaced while local fault holds
        mac_data = 32'h0BAD_F00D; mac_ctrl = 4'b0110;
        expect_state(3, 1'b1, 1'b0);
        send(0, 128);
        expect_state(8, 1'b0, 1'b0);

        // R6 a gap of 128 restarts the run
        send(1, 1);
        send(0, 128);
        send(1, 3);
        expect_state(6, 1'b0, 1'b0);
        send(1, 1);
        expect_state(6, 1'b1, 1'b0);

        // R1 reset clears a raised flag at once
        rst_n = 1'b0;
        expect_state(1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        send(0, 2);
        expect_state(1, 1'b0, 1'b0);

        finish_run();
    end
endmodule